// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block holds committed stores that are waiting to be written to memory. Stores, cache-maintenance operations and barrier markers enter at the tail. Stores and maintenance operations leave for memory in the order they arrived, through a request port with a configurable number of lanes. One lane serves one request, so the lane count caps how many are issued in a cycle. An issued entry keeps its slot until the memory side reports it done. That report may name any slot, and the entries left behind keep their relative order.

Barrier markers never reach memory. A barrier leaves only once everything older has drained, which is when it reaches the head. A run of barriers at the head is removed in one cycle, and the number removed is reported on the next cycle.

Loads query the buffer through a lookup port. The search runs from the youngest entry toward the oldest and stops at the first store from the same thread whose byte range overlaps the load. It reports whether that store covers the load fully, partly or not at all. On full coverage it returns the load's bytes taken from the store's data.

Top module: `store_buffer_fwd`

## Requirements
- R1: Stores and maintenance operations that have not been issued are presented on the request lanes oldest first. Lane 0 carries the oldest. The lanes are filled contiguously, and there are never more than ISSUE_MAX of them.
- R2: Lane k issues only when lanes 0..k-1 issue in the same cycle and mem_req_ready[k] is high. The first lane that is not ready blocks every later lane in that cycle.
- R3: in_full is high when all NSLOT slots are occupied. An insertion while in_full is high is dropped, and in_overflow is high for exactly the following cycle.
- R4: mem_done_valid with mem_done_slot frees that slot in any queue position. The remaining entries keep their relative order. A freed slot can be reused by a later insertion, which is placed at the tail. A newly inserted entry takes the lowest-numbered free slot.
- R5: Barrier entries (in_kind=2) are never issued. Every barrier in the contiguous run at the head of the queue is removed in the same cycle. bar_clear_cnt equals the number removed during the previous cycle.
- R6: unissued_cnt rises by one for each accepted store (in_kind=0) or maintenance entry (in_kind=1). It falls by the number of requests that issue in a cycle.
- R7: A load [la, la+ls) and a store [sa, sa+ss) do not overlap when la >= sa+ss or la+ls <= sa. This gives coverage none (fw_cov=0).
- R8: When the ranges overlap, coverage is full (fw_cov=2) if sa <= la and sa+ss >= la+ls. Otherwise it is partial (fw_cov=1).
- R9: The search goes from youngest to oldest. It considers only stores (in_kind=0) whose thread equals ld_tid, and it stops at the first one that overlaps. Barriers and maintenance entries are skipped.
- R10: On full coverage, fw_data holds the store's bytes starting at byte offset la-sa, in the lowest ld_size bytes, with zero above them. On partial coverage fw_slot names the store and fw_data is zero. On no coverage both fw_slot and fw_data are zero. The result appears one cycle after ld_valid.
- R11: After reset the buffer is empty. No lane is valid, every count is zero, and fw_valid and in_overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Insert an entry at the tail |
| in_kind | input | 2 | 0 store, 1 cache maintenance, 2 barrier |
| in_tid | input | TIDW | Thread of the entry |
| in_addr | input | AW | Byte address |
| in_size | input | SW | Size in bytes, 1..MAXB |
| in_data | input | 8*MAXB | Store bytes, byte 0 in the low bits |
| in_full | output | 1 | All slots occupied |
| in_overflow | output | 1 | Previous cycle's insertion was dropped |
| mem_req_valid | output | ISSUE_MAX | Lane holds an unissued request |
| mem_req_maint | output | ISSUE_MAX | Lane request is a maintenance operation |
| mem_req_addr | output | ISSUE_MAX*AW | Per-lane address |
| mem_req_size | output | ISSUE_MAX*SW | Per-lane size |
| mem_req_data | output | ISSUE_MAX*8*MAXB | Per-lane data |
| mem_req_slot | output | ISSUE_MAX*IDW | Per-lane slot number |
| mem_req_ready | input | ISSUE_MAX | Memory accepts the lane |
| mem_done_valid | input | 1 | An issued request has completed |
| mem_done_slot | input | IDW | Slot of the completed request |
| bar_clear_cnt | output | CW | Barriers removed in the previous cycle |
| unissued_cnt | output | CW | Occupied, unissued non-barrier entries |
| ld_valid | input | 1 | Forwarding lookup request |
| ld_tid | input | TIDW | Thread of the load |
| ld_addr | input | AW | Load address |
| ld_size | input | SW | Load size in bytes |
| fw_valid | output | 1 | Lookup result valid |
| fw_cov | output | 2 | 0 none, 1 partial, 2 full |
| fw_slot | output | IDW | Slot that matched |
| fw_data | output | 8*MAXB | Forwarded bytes |

## Verification
The hardest state to reach from the ports is a barrier that is held back only by older entries that have already been issued. It must sit behind those entries, and it has to drop out in the cycle after the last one completes, not earlier. The stimulus builds that state on purpose. It fills the queue with stores, a maintenance operation and barriers while every ready line is held low, issues the entries lane by lane, and then completes them out of order, first from the middle and then from the head. bar_clear_cnt is sampled on the completion edge and on the edge after it. A full sweep of load address and size around one store checks the coverage and forwarded bytes against interval arithmetic.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  typedef enum logic [1:0] {
    SB_STORE   = 2'd0,
    SB_MAINT   = 2'd1,
    SB_BARRIER = 2'd2
  } sb_kind_e;

  typedef enum logic [1:0] {
    COV_NONE    = 2'd0,
    COV_PARTIAL = 2'd1,
    COV_FULL    = 2'd2
  } sb_cov_e;
endpackage

// File: rtl/sb_forward.sv
`timescale 1ns/1ps
module sb_forward import sb_pkg::*; #(
  parameter int NSLOT = 4,
  parameter int AW    = 8,
  parameter int MAXB  = 4,
  parameter int TIDW  = 1,
  localparam int SW   = $clog2(MAXB + 1),
  localparam int IDW  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW   = $clog2(NSLOT + 1),
  localparam int DW   = 8 * MAXB,
  localparam int OFW  = (MAXB > 1) ? $clog2(MAXB) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ld_valid,
  input  logic [TIDW-1:0]                ld_tid,
  input  logic [AW-1:0]                  ld_addr,
  input  logic [SW-1:0]                  ld_size,
  input  logic [CW-1:0]                  cnt,
  input  logic [NSLOT-1:0][IDW-1:0]      ord,
  input  logic [NSLOT-1:0][AW-1:0]       e_addr,
  input  logic [NSLOT-1:0][SW-1:0]       e_size,
  input  logic [NSLOT-1:0][DW-1:0]       e_data,
  input  logic [NSLOT-1:0][TIDW-1:0]     e_tid,
  input  logic [NSLOT-1:0][1:0]          e_kind,
  output logic                           fw_valid,
  output logic [1:0]                     fw_cov,
  output logic [IDW-1:0]                 fw_slot,
  output logic [DW-1:0]                  fw_data
);
  sb_cov_e          cov;
  logic             hit;
  logic [IDW-1:0]   id, hslot;
  logic [AW:0]      l_end, s_end;
  logic [OFW-1:0]   off;
  logic [DW-1:0]    lmask, hdata;

  // byte mask of the load size
  always_comb begin
    lmask = '0;
    for (int b = 0; b < MAXB; b++)
      if (SW'(b) < ld_size) lmask[b*8 +: 8] = 8'hFF;
  end

  // youngest-to-oldest search, first overlapping eligible store wins
  always_comb begin
    hit   = 1'b0;
    cov   = COV_NONE;
    hslot = '0;
    hdata = '0;
    id    = '0;
    off   = '0;
    s_end = '0;
    l_end = {1'b0, ld_addr} + (AW+1)'(ld_size);
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!hit && (CW'(i) < cnt)) begin
        id    = ord[i];
        s_end = {1'b0, e_addr[id]} + (AW+1)'(e_size[id]);
        if (e_kind[id] == SB_STORE && e_tid[id] == ld_tid &&
            !(({1'b0, ld_addr} >= s_end) || (l_end <= {1'b0, e_addr[id]}))) begin
          hit   = 1'b1;
          hslot = id;
          if (ld_addr >= e_addr[id] && l_end <= s_end) begin
            cov   = COV_FULL;
            off   = OFW'(ld_addr - e_addr[id]);
            hdata = (e_data[id] >> {off, 3'b000}) & lmask;
          end else begin
            cov = COV_PARTIAL;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fw_valid <= 1'b0;
      fw_cov   <= COV_NONE;
      fw_slot  <= '0;
      fw_data  <= '0;
    end else begin
      fw_valid <= ld_valid;
      fw_cov   <= ld_valid ? cov : COV_NONE;
      fw_slot  <= ld_valid ? hslot : '0;
      fw_data  <= ld_valid ? hdata : '0;
    end
  end

  // R10: forwarded data only accompanies full coverage
  p_data_only_full_r10: assert property (@(posedge clk) disable iff (rst)
    (fw_cov != COV_FULL) |-> (fw_data == '0));
endmodule

// File: rtl/sb_issue_sel.sv
`timescale 1ns/1ps
module sb_issue_sel #(
  parameter int NSLOT     = 4,
  parameter int ISSUE_MAX = 2,
  localparam int IDW      = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW       = $clog2(NSLOT + 1)
) (
  input  logic [CW-1:0]                  cnt,
  input  logic [NSLOT-1:0][IDW-1:0]      ord,
  input  logic [NSLOT-1:0]               cand,
  input  logic [ISSUE_MAX-1:0]           ready,
  output logic [ISSUE_MAX-1:0]           lane_v,
  output logic [ISSUE_MAX-1:0][IDW-1:0]  lane_id,
  output logic [ISSUE_MAX-1:0]           fire
);
  int k;
  logic gate;

  // oldest unissued candidates fill lanes in order
  always_comb begin
    k       = 0;
    lane_v  = '0;
    lane_id = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if ((CW'(i) < cnt) && cand[ord[i]] && (k < ISSUE_MAX)) begin
        lane_v[k]  = 1'b1;
        lane_id[k] = ord[i];
        k          = k + 1;
      end
    end
  end

  // a lane fires only if all earlier lanes fire
  always_comb begin
    gate = 1'b1;
    for (int l = 0; l < ISSUE_MAX; l++) begin
      fire[l] = gate & lane_v[l] & ready[l];
      gate    = fire[l];
    end
  end
endmodule

// File: rtl/store_buffer_fwd.sv
`timescale 1ns/1ps
module store_buffer_fwd import sb_pkg::*; #(
  parameter int NSLOT     = 4,
  parameter int AW        = 8,
  parameter int MAXB      = 4,
  parameter int ISSUE_MAX = 2,
  parameter int TIDW      = 1,
  localparam int SW       = $clog2(MAXB + 1),
  localparam int IDW      = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW       = $clog2(NSLOT + 1),
  localparam int DW       = 8 * MAXB
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [1:0]                in_kind,
  input  logic [TIDW-1:0]           in_tid,
  input  logic [AW-1:0]             in_addr,
  input  logic [SW-1:0]             in_size,
  input  logic [DW-1:0]             in_data,
  output logic                      in_full,
  output logic                      in_overflow,
  output logic [ISSUE_MAX-1:0]      mem_req_valid,
  output logic [ISSUE_MAX-1:0]      mem_req_maint,
  output logic [ISSUE_MAX*AW-1:0]   mem_req_addr,
  output logic [ISSUE_MAX*SW-1:0]   mem_req_size,
  output logic [ISSUE_MAX*DW-1:0]   mem_req_data,
  output logic [ISSUE_MAX*IDW-1:0]  mem_req_slot,
  input  logic [ISSUE_MAX-1:0]      mem_req_ready,
  input  logic                      mem_done_valid,
  input  logic [IDW-1:0]            mem_done_slot,
  output logic [CW-1:0]             bar_clear_cnt,
  output logic [CW-1:0]             unissued_cnt,
  input  logic                      ld_valid,
  input  logic [TIDW-1:0]           ld_tid,
  input  logic [AW-1:0]             ld_addr,
  input  logic [SW-1:0]             ld_size,
  output logic                      fw_valid,
  output logic [1:0]                fw_cov,
  output logic [IDW-1:0]            fw_slot,
  output logic [DW-1:0]             fw_data
);
  // slot storage, written only on insertion
  logic [NSLOT-1:0][AW-1:0]   addr_q;
  logic [NSLOT-1:0][SW-1:0]   size_q;
  logic [NSLOT-1:0][DW-1:0]   data_q;
  logic [NSLOT-1:0][TIDW-1:0] tid_q;
  logic [NSLOT-1:0][1:0]      kind_q;
  logic [NSLOT-1:0]           used_q, issued_q;
  // age order of occupied slots, position 0 is oldest
  logic [NSLOT-1:0][IDW-1:0]  ord_q, nord;
  logic [CW-1:0]              cnt_q, ncnt;
  logic [CW-1:0]              unissued_q, bar_clr_q;
  logic                       ovf_q;

  logic [IDW-1:0]             free_id;
  logic                       free_found, ins_ok, ins_nb;
  logic [NSLOT-1:0]           keep, drop_bar, freed, ins_mask, fired_phys;
  logic [NSLOT-1:0]           cand, nonbar;
  logic                       run;
  int                         j;

  logic [ISSUE_MAX-1:0]            lane_v, fire;
  logic [ISSUE_MAX-1:0][IDW-1:0]   lane_id;

  assign in_full = (cnt_q == CW'(NSLOT));
  assign ins_ok  = in_valid && !in_full;
  assign ins_nb  = ins_ok && (in_kind != SB_BARRIER);

  always_comb begin
    free_id    = '0;
    free_found = 1'b0;
    for (int i = 0; i < NSLOT; i++)
      if (!used_q[i] && !free_found) begin
        free_id    = IDW'(i);
        free_found = 1'b1;
      end
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      nonbar[i] = (kind_q[i] != SB_BARRIER);
      cand[i]   = used_q[i] && !issued_q[i] && nonbar[i];
    end
  end

  // removal: head barrier run, plus the completed slot
  always_comb begin
    run      = 1'b1;
    drop_bar = '0;
    keep     = '0;
    freed    = '0;
    for (int i = 0; i < NSLOT; i++) begin
      run         = run && (CW'(i) < cnt_q) && (kind_q[ord_q[i]] == SB_BARRIER);
      drop_bar[i] = run;
      keep[i]     = (CW'(i) < cnt_q) && !run &&
                    !(mem_done_valid && ord_q[i] == mem_done_slot);
      if ((CW'(i) < cnt_q) && !keep[i]) freed[ord_q[i]] = 1'b1;
    end
  end

  // compaction of survivors, then append the new entry
  always_comb begin
    nord = '0;
    j    = 0;
    for (int i = 0; i < NSLOT; i++)
      if (keep[i]) begin
        nord[j] = ord_q[i];
        j       = j + 1;
      end
    if (ins_ok && j < NSLOT) begin
      nord[j] = free_id;
      j       = j + 1;
    end
    ncnt = CW'(j);
  end

  always_comb begin
    ins_mask = '0;
    if (ins_ok) ins_mask[free_id] = 1'b1;
    fired_phys = '0;
    for (int l = 0; l < ISSUE_MAX; l++)
      if (fire[l]) fired_phys[lane_id[l]] = 1'b1;
  end

  sb_issue_sel #(.NSLOT(NSLOT), .ISSUE_MAX(ISSUE_MAX)) i_issue (
    .cnt     (cnt_q),
    .ord     (ord_q),
    .cand    (cand),
    .ready   (mem_req_ready),
    .lane_v  (lane_v),
    .lane_id (lane_id),
    .fire    (fire)
  );

  generate
    for (genvar g = 0; g < ISSUE_MAX; g++) begin : g_lane
      assign mem_req_addr[g*AW +: AW]   = addr_q[lane_id[g]];
      assign mem_req_size[g*SW +: SW]   = size_q[lane_id[g]];
      assign mem_req_data[g*DW +: DW]   = data_q[lane_id[g]];
      assign mem_req_slot[g*IDW +: IDW] = lane_id[g];
      assign mem_req_maint[g]           = lane_v[g] && (kind_q[lane_id[g]] == SB_MAINT);
    end
  endgenerate
  assign mem_req_valid = lane_v;

  always_ff @(posedge clk) begin
    if (ins_ok) begin
      addr_q[free_id] <= in_addr;
      size_q[free_id] <= in_size;
      data_q[free_id] <= in_data;
      tid_q[free_id]  <= in_tid;
      kind_q[free_id] <= in_kind;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q     <= '0;
      issued_q   <= '0;
      ord_q      <= '0;
      cnt_q      <= '0;
      unissued_q <= '0;
      bar_clr_q  <= '0;
      ovf_q      <= 1'b0;
    end else begin
      used_q     <= (used_q & ~freed) | ins_mask;
      issued_q   <= (issued_q | fired_phys) & ~ins_mask;
      ord_q      <= nord;
      cnt_q      <= ncnt;
      unissued_q <= unissued_q + CW'(ins_nb) - CW'($countones(fire));
      bar_clr_q  <= CW'($countones(drop_bar));
      ovf_q      <= in_valid && !ins_ok;
    end
  end

  assign unissued_cnt  = unissued_q;
  assign bar_clear_cnt = bar_clr_q;
  assign in_overflow   = ovf_q;

  sb_forward #(.NSLOT(NSLOT), .AW(AW), .MAXB(MAXB), .TIDW(TIDW)) i_fwd (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .ld_tid   (ld_tid),
    .ld_addr  (ld_addr),
    .ld_size  (ld_size),
    .cnt      (cnt_q),
    .ord      (ord_q),
    .e_addr   (addr_q),
    .e_size   (size_q),
    .e_data   (data_q),
    .e_tid    (tid_q),
    .e_kind   (kind_q),
    .fw_valid (fw_valid),
    .fw_cov   (fw_cov),
    .fw_slot  (fw_slot),
    .fw_data  (fw_data)
  );

  // R3: occupancy never exceeds the slot count
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(NSLOT));
  // R3: insertion into a full buffer is flagged next cycle
  p_drop_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_full) |=> in_overflow);
  // R4: completion only for an occupied, issued slot
  p_done_issued_r4: assert property (@(posedge clk) disable iff (rst)
    mem_done_valid |-> (used_q[mem_done_slot] && issued_q[mem_done_slot]));
  // R6: counter agrees with slot state
  p_unissued_track_r6: assert property (@(posedge clk) disable iff (rst)
    unissued_q == CW'($countones(used_q & ~issued_q & nonbar)));
  // R5: cannot clear more barriers than were held
  p_bar_bound_r5: assert property (@(posedge clk) disable iff (rst)
    bar_clear_cnt <= $past(cnt_q));
endmodule

// File: tb/test_store_buffer_fwd.sv
`timescale 1ns/1ps
module test_store_buffer_fwd;
  localparam int NSLOT = 4, AW = 8, MAXB = 4, IM = 2, TIDW = 1;
  localparam int SW = 3, IDW = 2, CW = 3, DW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0; logic [1:0] in_kind = 0; logic [TIDW-1:0] in_tid = 0;
  logic [AW-1:0] in_addr = 0; logic [SW-1:0] in_size = 0; logic [DW-1:0] in_data = 0;
  logic in_full, in_overflow;
  logic [IM-1:0] mem_req_valid, mem_req_maint;
  logic [IM*AW-1:0] mem_req_addr; logic [IM*SW-1:0] mem_req_size;
  logic [IM*DW-1:0] mem_req_data; logic [IM*IDW-1:0] mem_req_slot;
  logic [IM-1:0] mem_req_ready = 0;
  logic mem_done_valid = 0; logic [IDW-1:0] mem_done_slot = 0;
  logic [CW-1:0] bar_clear_cnt, unissued_cnt;
  logic ld_valid = 0; logic [TIDW-1:0] ld_tid = 0; logic [AW-1:0] ld_addr = 0;
  logic [SW-1:0] ld_size = 0;
  logic fw_valid; logic [1:0] fw_cov; logic [IDW-1:0] fw_slot; logic [DW-1:0] fw_data;

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  store_buffer_fwd #(.NSLOT(NSLOT), .AW(AW), .MAXB(MAXB), .ISSUE_MAX(IM), .TIDW(TIDW)) i_store_buffer_fwd (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_tid(in_tid),
    .in_addr(in_addr), .in_size(in_size), .in_data(in_data), .in_full(in_full),
    .in_overflow(in_overflow), .mem_req_valid(mem_req_valid), .mem_req_maint(mem_req_maint),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size), .mem_req_data(mem_req_data),
    .mem_req_slot(mem_req_slot), .mem_req_ready(mem_req_ready), .mem_done_valid(mem_done_valid),
    .mem_done_slot(mem_done_slot), .bar_clear_cnt(bar_clear_cnt), .unissued_cnt(unissued_cnt),
    .ld_valid(ld_valid), .ld_tid(ld_tid), .ld_addr(ld_addr), .ld_size(ld_size),
    .fw_valid(fw_valid), .fw_cov(fw_cov), .fw_slot(fw_slot), .fw_data(fw_data));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ins(input logic [1:0] k, input logic t, input logic [7:0] a,
                     input logic [2:0] s, input logic [31:0] d);
    in_valid = 1; in_kind = k; in_tid = t; in_addr = a; in_size = s; in_data = d;
    cyc();
    in_valid = 0;
  endtask

  task automatic lk(input logic t, input logic [7:0] a, input logic [2:0] s);
    ld_valid = 1; ld_tid = t; ld_addr = a; ld_size = s;
    cyc();
    ld_valid = 0;
  endtask

  task automatic done(input logic [1:0] sl);
    mem_done_valid = 1; mem_done_slot = sl;
    cyc();
    mem_done_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    // R11 reset state
    chk("R11 full", in_full, 0);
    chk("R11 lanes", mem_req_valid, 0);
    chk("R11 unissued", unissued_cnt, 0);
    chk("R11 barclr", bar_clear_cnt, 0);
    chk("R11 fwvalid", fw_valid, 0);
    chk("R11 ovf", in_overflow, 0);

    // one store at 8..11, slot 0
    ins(0, 0, 8'd8, 3'd4, 32'hDDCCBBAA);
    chk("R6 unissued after store", unissued_cnt, 1);
    chk("R1 single lane", mem_req_valid, 2'b01);
    chk("R1 lane0 addr", mem_req_addr[7:0], 8);

    // coverage sweep
    for (int a = 4; a <= 13; a++) begin
      for (int s = 1; s <= 4; s++) begin
        int le; int ec; logic [63:0] ed;
        le = a + s;
        ed = 0;
        if (a >= 12 || le <= 8) ec = 0;
        else if (a >= 8 && le <= 12) begin
          ec = 2;
          ed = (64'hDDCCBBAA >> (8 * (a - 8))) & ((64'd1 << (8 * s)) - 1);
        end else ec = 1;
        lk(0, 8'(a), 3'(s));
        chk(ec == 0 ? "R7 cov none" : "R8 cov class", fw_cov, ec);
        chk("R10 fw data", fw_data, ed);
        chk("R10 fw slot", fw_slot, 0);
        chk("R10 fw valid", fw_valid, 1);
      end
    end

    lk(1, 8'd8, 3'd4);
    chk("R9 other thread none", fw_cov, 0);

    ins(1, 0, 8'd8, 3'd4, 32'h0);          // maintenance, slot 1
    lk(0, 8'd9, 3'd1);
    chk("R9 maint skipped cov", fw_cov, 2);
    chk("R9 maint skipped data", fw_data, 32'hBB);
    chk("R9 maint skipped slot", fw_slot, 0);

    ins(0, 0, 8'd10, 3'd2, 32'h5566);      // slot 2
    lk(0, 8'd8, 3'd4);
    chk("R9 youngest partial cov", fw_cov, 1);
    chk("R10 partial slot", fw_slot, 2);
    chk("R10 partial data zero", fw_data, 0);
    lk(0, 8'd10, 3'd2);
    chk("R9 youngest full", fw_cov, 2);
    chk("R10 youngest data", fw_data, 32'h5566);
    lk(0, 8'd8, 3'd2);
    chk("R9 older full slot", fw_slot, 0);
    chk("R10 older data", fw_data, 32'hBBAA);
    lk(0, 8'd11, 3'd1);
    chk("R10 offset data", fw_data, 32'h55);

    ins(2, 0, 8'd0, 3'd1, 32'h0);          // barrier, slot 3
    lk(0, 8'd10, 3'd1);
    chk("R9 barrier skipped", fw_slot, 2);
    chk("R10 byte data", fw_data, 32'h66);
    chk("R3 full flag", in_full, 1);
    chk("R6 barrier not counted", unissued_cnt, 3);
    chk("R5 barrier not at head", bar_clear_cnt, 0);

    ins(0, 0, 8'h30, 3'd1, 32'h99);        // dropped
    chk("R3 overflow pulse", in_overflow, 1);
    chk("R3 unissued unchanged", unissued_cnt, 3);
    lk(0, 8'h30, 3'd1);
    chk("R3 dropped not stored", fw_cov, 0);
    chk("R3 overflow one cycle", in_overflow, 0);

    // issue ordering
    chk("R1 two lanes", mem_req_valid, 2'b11);
    chk("R1 lane0 slot", mem_req_slot[1:0], 0);
    chk("R1 lane1 slot", mem_req_slot[3:2], 1);
    chk("R1 lane1 maint", mem_req_maint, 2'b10);
    mem_req_ready = 2'b10;
    cyc();
    chk("R2 blocked by lane0", unissued_cnt, 3);
    mem_req_ready = 2'b01;
    cyc();
    chk("R2 only lane0 issued", unissued_cnt, 2);
    chk("R1 next lane0 slot", mem_req_slot[1:0], 1);
    chk("R1 next lane1 slot", mem_req_slot[3:2], 2);
    chk("R1 next lane1 addr", mem_req_addr[15:8], 10);
    mem_req_ready = 2'b11;
    cyc();
    mem_req_ready = 2'b00;
    chk("R6 all issued", unissued_cnt, 0);
    chk("R5 barrier never issued", mem_req_valid, 0);

    // delete from the middle
    done(1);
    chk("R4 not full", in_full, 0);
    lk(0, 8'd10, 3'd2);
    chk("R4 survivor intact", fw_slot, 2);
    ins(0, 0, 8'h40, 3'd1, 32'h77);        // reuses slot 1
    chk("R4 new entry lane", mem_req_valid, 2'b01);
    chk("R4 reused slot", mem_req_slot[1:0], 1);
    chk("R4 new entry addr", mem_req_addr[7:0], 8'h40);
    lk(0, 8'h40, 3'd1);
    chk("R4 new entry fwd", fw_data, 32'h77);
    done(0);
    chk("R5 barrier held", bar_clear_cnt, 0);
    done(2);
    chk("R5 no pop on done edge", bar_clear_cnt, 0);
    cyc();
    chk("R5 one barrier popped", bar_clear_cnt, 1);
    cyc();
    chk("R5 pulse ends", bar_clear_cnt, 0);
    mem_req_ready = 2'b01;
    cyc();
    mem_req_ready = 2'b00;
    done(1);
    chk("R6 empty count", unissued_cnt, 0);
    chk("R4 empty lanes", mem_req_valid, 0);

    // barrier run behind an issued store
    ins(0, 1, 8'h20, 3'd4, 32'h11223344);
    ins(2, 0, 8'h0, 3'd1, 32'h0);
    ins(2, 1, 8'h0, 3'd1, 32'h0);
    chk("R6 store only", unissued_cnt, 1);
    lk(1, 8'h22, 3'd2);
    chk("R10 other thread data", fw_data, 32'h1122);
    mem_req_ready = 2'b11;
    cyc();
    mem_req_ready = 2'b00;
    chk("R5 barriers never on lanes", mem_req_valid, 0);
    done(0);
    chk("R5 held until drained", bar_clear_cnt, 0);
    cyc();
    chk("R5 run of two popped", bar_clear_cnt, 2);
    chk("R5 buffer empty", in_full, 0);

    // barrier into empty buffer
    ins(2, 0, 8'h0, 3'd1, 32'h0);
    chk("R5 not yet popped", bar_clear_cnt, 0);
    cyc();
    chk("R5 head barrier popped", bar_clear_cnt, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule